// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

This block controls one bank of up to 32 general-purpose pins through a 32-bit register interface. Each pin is configured independently. It can be a plain input, a plain output, or an interrupt input. An interrupt input senses either a level or an edge. Its polarity is selectable, and a build option adds detection of both edges. The per-pin interrupt conditions feed a status vector, which passes through an enable mask to one combined interrupt output.

Software configures a pin by writing the mode, direction, polarity and sense-type registers. Interrupts are enabled through a dedicated unmask port and disabled through the mask port. Latched edge events are acknowledged by writing 1 to the matching bit of the clear port. Pin inputs are synchronised by two flip-flops before they reach any sensing or read-back logic.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `pin_oe` is all zeros and `irq` is low, so every pin starts as a masked general input.
- R2: Register word offsets are: mode 0x00 (1 = interrupt input), direction 0x04 (1 = output), output data 0x08, input data 0x0C, status 0x10, clear 0x14, mask 0x18, unmask 0x1C, polarity 0x20, sense type 0x24 (1 = edge), both-edge 0x4C. Write-only ports and unused offsets read 0. Read data appears on `bus_rdata` one cycle after the read request and holds until the next read.
- R3: A pin with mode 0 and direction 1 has its `pin_oe` bit set, and `pin_out` carries the output-data register. A pin in interrupt mode is never driven.
- R4: A read of input data returns the output-data bit for output pins and the synchronised pin level for every other pin. A pin change is visible to a read issued two cycles later.
- R5: An edge-sensing interrupt pin with polarity 0 latches its status bit on a rising edge and with polarity 1 on a falling edge. The bit is set three clock edges after the pin changes.
- R6: Writing 1 to a clear bit resets that pin's latched edge status. Bits written as 0 have no effect.
- R7: A write to the unmask port sets the mask bits written as 1. A write to the mask port clears the bits written as 0 and leaves the others unchanged. A mask bit reads 1 when the pin's interrupt is enabled.
- R8: `irq` is high exactly while some status bit and its mask bit are both 1. It responds to a mask change in the cycle after the write.
- R9: A level-sensing interrupt pin's status follows the polarity-adjusted synchronised level two edges after a pin change. A clear write has no lasting effect while the level stays asserted.
- R10: With `BOTH_EDGE_EN` = 1, a set both-edge bit latches on either transition of an edge pin regardless of polarity. With `BOTH_EDGE_EN` = 0, the both-edge register reads 0, ignores writes, and only the polarity edge is latched.
- R11: Pins in general IO mode never set a status bit, whatever their pin activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read request |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output-data register value |
| pin_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Combined enabled interrupt |

## Verification
A register write takes effect at the clock edge where it is presented, so `pin_oe`, `pin_out`, the mask and `irq` gating are checked on the falling edge after that edge. A read result is sampled on the falling edge after the request edge. After a pin change, a level status and the input-data view are due after two rising edges, and an edge status after three. The edge tests check that `irq` is still low after the second edge and high after the third, which pins the latency exactly. All stimulus is applied and all outputs are sampled on falling edges.

// File: rtl/gpio_bank_pkg.sv
// Shared register offsets for the GPIO bank.
// Assumes byte addressing of 32-bit words; the low two address bits are zero.
package gpio_bank_pkg;
    localparam int ADDR_W = 7;
    localparam logic [ADDR_W-1:0] OFS_MODE   = 7'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR    = 7'h04;
    localparam logic [ADDR_W-1:0] OFS_DOUT   = 7'h08;
    localparam logic [ADDR_W-1:0] OFS_DIN    = 7'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 7'h10;
    localparam logic [ADDR_W-1:0] OFS_CLR    = 7'h14;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 7'h18;
    localparam logic [ADDR_W-1:0] OFS_UNMASK = 7'h1C;
    localparam logic [ADDR_W-1:0] OFS_POL    = 7'h20;
    localparam logic [ADDR_W-1:0] OFS_SENSE  = 7'h24;
    localparam logic [ADDR_W-1:0] OFS_BOTH   = 7'h4C;
endpackage

// File: rtl/gpio_bank_sync.sv
// Two-flop synchroniser for the pin input vector.
// Assumes each pin is an independent asynchronous signal; no bus coherency is implied.
module gpio_bank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gpio_bank_regs.sv
// Configuration and mask registers of the GPIO bank.
// Assumes the write strobe is one cycle wide; produces a one-cycle clear pulse vector.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPINS        = 32,
    parameter bit BOTH_EDGE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    output logic [NPINS-1:0]  mode,
    output logic [NPINS-1:0]  dir,
    output logic [NPINS-1:0]  dout,
    output logic [NPINS-1:0]  pol,
    output logic [NPINS-1:0]  sense_edge,
    output logic [NPINS-1:0]  both,
    output logic [NPINS-1:0]  mask,
    output logic [NPINS-1:0]  clr_pulse
);
    // Clear port produces a pulse, no storage.
    always_comb clr_pulse = (wr_en && wr_addr == OFS_CLR) ? wr_data : '0;

    // Plain read/write configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= '0;
            dir        <= '0;
            dout       <= '0;
            pol        <= '0;
            sense_edge <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                OFS_MODE:  mode       <= wr_data;
                OFS_DIR:   dir        <= wr_data;
                OFS_DOUT:  dout       <= wr_data;
                OFS_POL:   pol        <= wr_data;
                OFS_SENSE: sense_edge <= wr_data;
                default: ;
            endcase
        end
    end

    // Mask: the mask port ANDs the written value, the unmask port ORs it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (wr_en && wr_addr == OFS_MASK)
            mask <= mask & wr_data;
        else if (wr_en && wr_addr == OFS_UNMASK)
            mask <= mask | wr_data;
    end

    generate
        if (BOTH_EDGE_EN) begin : g_both
            // Both-edge select register, present only when the option is built.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    both <= '0;
                else if (wr_en && wr_addr == OFS_BOTH)
                    both <= wr_data;
            end
        end else begin : g_no_both
            assign both = '0;
        end
    endgenerate

    // R7: mask port only clears bits written as 0.
    p_mask_and_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_MASK) |=> (mask == ($past(mask) & $past(wr_data))));

    // R7: unmask port enables every bit written as 1.
    p_unmask_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_UNMASK) |=> ((mask & $past(wr_data)) == $past(wr_data)));
endmodule

// File: rtl/gpio_bank_sense.sv
// Interrupt sensing for each pin: edge latching and level tracking.
// Assumes pin_lvl is already synchronised; both is all-zero when the option is absent.
module gpio_bank_sense #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic [NPINS-1:0] mode,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] sense_edge,
    input  logic [NPINS-1:0] both,
    input  logic [NPINS-1:0] clr_pulse,
    output logic [NPINS-1:0] status
);
    logic [NPINS-1:0] prev_lvl;
    logic [NPINS-1:0] latched;
    logic [NPINS-1:0] events;
    logic [NPINS-1:0] edge_sel;
    logic [NPINS-1:0] level_hit;

    always_comb edge_sel  = mode & sense_edge;
    always_comb level_hit = mode & ~sense_edge & (pin_lvl ^ pol);

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            logic rise, fall;
            assign rise = pin_lvl[i] & ~prev_lvl[i];
            assign fall = ~pin_lvl[i] & prev_lvl[i];
            // Per-pin event picks the transition that polarity or both-edge asks for.
            assign events[i] = edge_sel[i] &
                (both[i] ? (rise | fall) : (pol[i] ? fall : rise));
        end
    endgenerate

    // Previous synchronised level, for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= '0;
        else        prev_lvl <= pin_lvl;
    end

    // Latched edge status; a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) latched <= '0;
        else        latched <= ((latched & ~clr_pulse) | events) & edge_sel;
    end

    always_comb status = latched | level_hit;

    // R6: a cleared bit with no new event is zero afterwards.
    p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse != '0) |=> ((latched & $past(clr_pulse & ~events)) == '0));

    // R5: latched bits are never set without an event.
    p_no_spurious_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (events == '0) |=> ((latched & ~$past(latched)) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
// GPIO bank top: register read path, pin drive and combined interrupt.
// Assumes single-cycle bus requests; read data is registered and held between reads.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS        = 32,
    parameter bit BOTH_EDGE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] mode, dir, dout, pol, sense_edge, both, mask, clr_pulse;
    logic [NPINS-1:0] pin_lvl, status, din_view, rd_sel;
    logic             wr_en;

    assign wr_en = bus_valid & bus_write;

    gpio_bank_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_lvl)
    );

    gpio_bank_regs #(.NPINS(NPINS), .BOTH_EDGE_EN(BOTH_EDGE_EN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(bus_addr),
        .wr_data(bus_wdata[NPINS-1:0]), .mode(mode), .dir(dir), .dout(dout),
        .pol(pol), .sense_edge(sense_edge), .both(both), .mask(mask),
        .clr_pulse(clr_pulse)
    );

    gpio_bank_sense #(.NPINS(NPINS)) u_sense (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .mode(mode), .pol(pol),
        .sense_edge(sense_edge), .both(both), .clr_pulse(clr_pulse), .status(status)
    );

    // Pin drive: only general IO pins set as outputs are enabled.
    always_comb begin
        pin_out = dout;
        pin_oe  = dir & ~mode;
    end

    // Input-data view: output pins reflect the output register.
    always_comb din_view = (pin_oe & dout) | (~pin_oe & pin_lvl);

    // Combined enabled interrupt.
    always_comb irq = |(status & mask);

    // Read multiplexer over the register offsets.
    always_comb begin
        case (bus_addr)
            OFS_MODE:  rd_sel = mode;
            OFS_DIR:   rd_sel = dir;
            OFS_DOUT:  rd_sel = dout;
            OFS_DIN:   rd_sel = din_view;
            OFS_STAT:  rd_sel = status;
            OFS_MASK:  rd_sel = mask;
            OFS_POL:   rd_sel = pol;
            OFS_SENSE: rd_sel = sense_edge;
            OFS_BOTH:  rd_sel = both;
            default:   rd_sel = '0;
        endcase
    end

    // Registered read data, updated only on read requests.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_valid && !bus_write) begin
            bus_rdata <= '0;
            bus_rdata[NPINS-1:0] <= rd_sel;
        end
    end

    // R1: first cycle out of reset is quiet.
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!irq && pin_oe == '0));
endmodule

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, rdata_nb;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, pin_out_nb, pin_oe_nb;
    logic        irq, irq_nb;
    int          n_chk = 0;
    int          n_fail = 0;

    localparam logic [6:0] A_MODE = 7'h00, A_DIR = 7'h04, A_DOUT = 7'h08, A_DIN = 7'h0C,
        A_STAT = 7'h10, A_CLR = 7'h14, A_MASK = 7'h18, A_UNMASK = 7'h1C,
        A_POL = 7'h20, A_SENSE = 7'h24, A_BOTH = 7'h4C;

    always #5 clk = ~clk;

    gpio_irq_bank #(.NPINS(32), .BOTH_EDGE_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    gpio_irq_bank #(.NPINS(32), .BOTH_EDGE_EN(1'b0)) uut_nb (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_nb),
        .pin_in(pin_in), .pin_out(pin_out_nb), .pin_oe(pin_oe_nb), .irq(irq_nb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        step(1);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pin_in = '0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        rd(A_MODE, d);  check("R1 mode", d, 32'h0);
        rd(A_DIR, d);   check("R1 dir", d, 32'h0);
        rd(A_MASK, d);  check("R1 mask", d, 32'h0);
        rd(A_STAT, d);  check("R1 status", d, 32'h0);
    endtask

    task automatic t_gpio();
        logic [31:0] d;
        do_reset();
        pin_in = 32'h0000_00F0;
        wr(A_DOUT, 32'h0000_00A5);
        wr(A_DIR, 32'h0000_000F);
        check("R3 pin_oe", pin_oe, 32'h0000_000F);
        check("R3 pin_out", pin_out, 32'h0000_00A5);
        step(2);
        rd(A_DIN, d); check("R4 input view", d, 32'h0000_00F5);
        rd(A_DOUT, d); check("R2 readback dout", d, 32'h0000_00A5);
        rd(A_CLR, d); check("R2 write-only reads 0", d, 32'h0);
        wr(A_MODE, 32'h0000_0001);
        check("R3 interrupt pin not driven", pin_oe, 32'h0000_000E);
    endtask

    task automatic t_rise();
        logic [31:0] d;
        do_reset();
        wr(A_SENSE, 32'h10);
        wr(A_MODE, 32'h10);
        pin_in[4] = 1'b1;
        step(3);
        rd(A_STAT, d); check("R5 rising latched", d, 32'h10);
        check("R8 masked irq low", {31'b0, irq}, 32'h0);
        wr(A_UNMASK, 32'h10);
        check("R8 irq after unmask", {31'b0, irq}, 32'h1);
        pin_in[4] = 1'b0;
        step(3);
        wr(A_CLR, 32'hFFFF_FFEF);
        check("R6 zero bits no effect", {31'b0, irq}, 32'h1);
        wr(A_CLR, 32'h10);
        check("R6 clear drops irq", {31'b0, irq}, 32'h0);
        pin_in[4] = 1'b1;
        step(2);
        check("R5 not yet at 2nd edge", {31'b0, irq}, 32'h0);
        step(1);
        check("R5 set at 3rd edge", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_fall();
        logic [31:0] d;
        do_reset();
        wr(A_POL, 32'h8); wr(A_SENSE, 32'h8); wr(A_MODE, 32'h8); wr(A_UNMASK, 32'h8);
        pin_in[3] = 1'b1;
        step(4);
        check("R5 falling ignores rise", {31'b0, irq}, 32'h0);
        pin_in[3] = 1'b0;
        step(3);
        rd(A_STAT, d); check("R5 falling latched", d, 32'h8);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        do_reset();
        wr(A_UNMASK, 32'hFF); rd(A_MASK, d); check("R7 unmask", d, 32'hFF);
        wr(A_MASK, 32'hF0);   rd(A_MASK, d); check("R7 mask and", d, 32'hF0);
        wr(A_MASK, 32'hFFFF_FF3C); rd(A_MASK, d); check("R7 mask keep ones", d, 32'h30);
        rd(A_UNMASK, d); check("R2 unmask reads 0", d, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        do_reset();
        wr(A_MODE, 32'h4); wr(A_UNMASK, 32'h4);
        pin_in[2] = 1'b1;
        step(1);
        check("R9 level not yet", {31'b0, irq}, 32'h0);
        step(1);
        check("R9 level high", {31'b0, irq}, 32'h1);
        wr(A_CLR, 32'h4);
        rd(A_STAT, d); check("R9 clear no effect", d, 32'h4);
        pin_in[2] = 1'b0;
        step(2);
        check("R9 level released", {31'b0, irq}, 32'h0);
        wr(A_POL, 32'h4);
        check("R9 active low asserts", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_both();
        logic [31:0] d;
        do_reset();
        wr(A_BOTH, 32'h40); rd(A_BOTH, d); check("R10 both readback", d, 32'h40);
        d = rdata_nb; check("R10 disabled reads 0", d, 32'h0);
        wr(A_SENSE, 32'h40); wr(A_MODE, 32'h40); wr(A_UNMASK, 32'h40);
        pin_in[6] = 1'b1;
        step(3);
        check("R10 rise", {31'b0, irq}, 32'h1);
        wr(A_CLR, 32'h40);
        pin_in[6] = 1'b0;
        step(3);
        check("R10 fall", {31'b0, irq}, 32'h1);
        check("R10 no fall when disabled", {31'b0, irq_nb}, 32'h0);
    endtask

    task automatic t_gpio_quiet();
        logic [31:0] d;
        do_reset();
        wr(A_SENSE, 32'h2); wr(A_UNMASK, 32'h2);
        pin_in[1] = 1'b1; step(3);
        pin_in[1] = 1'b0; step(3);
        rd(A_STAT, d); check("R11 general pin no status", d, 32'h0);
        check("R11 irq low", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        step(3);
        t_reset();
        t_gpio();
        t_rise();
        t_fall();
        t_mask();
        t_level();
        t_both();
        t_gpio_quiet();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule